// File: doc/BRIEF.md
# Dual-Producer Tagged Sample FIFO

This block is a small shared buffer that sits between two independent analog conversion paths and a processor. Each path hands over a finished result as a 12-bit value plus a 4-bit channel tag. The block packs the two into one 16-bit word and keeps up to eight words in arrival order. Software drains the buffer through one read port. Each read strobe removes the oldest word and loads it into a data register.

Both paths may deliver in the same clock cycle. In that case both words are stored in that cycle, and a fixed priority sets their order: the first path's word goes ahead of the second's. When the buffer cannot take every word offered, the extra words are dropped and a sticky overflow flag records the loss. The block exposes the fill level, empty and full flags, and an interrupt. The interrupt is raised while the buffer is full and the interrupt enable is set.

Top module: `tagged_sample_fifo`

## Requirements
- R1: Each stored word carries the channel tag in bits [15:12] and the sample value in bits [11:0]. Words are read out in the order they were stored.
- R2: When both paths offer a word in the same cycle and at least two slots are free, both are stored in that cycle. The level rises by two, and the first path's word is read out before the second path's word.
- R3: When both paths offer a word while exactly one slot is free and no read is made, the first path's word is stored and the second path's word is dropped. The buffer becomes full and the overflow flag is set.
- R4: A word offered while the buffer is full and no read is made is discarded. The stored contents and level stay unchanged. The overflow flag is set and stays set until reset.
- R5: A read strobe while the buffer is empty loads zero into the data register and leaves the level unchanged. A word pushed in that same cycle is still stored.
- R6: A push together with a read while the buffer is full is accepted. The level stays at eight, the read returns the oldest word, and the new word becomes the newest entry.
- R7: After reset the level is 0, empty is 1, full is 0, overflow is 0 and the read data is zero. At all times level counts the stored words, empty means level 0, and full means level 8.
- R8: The interrupt is 1 exactly when the buffer is full and the interrupt enable is 1. With the enable at 0 it stays 0.
- R9: The read data register takes its new value at the clock edge that samples the read strobe. It holds that value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | First path offers a word this cycle |
| a_value | input | 12 | First path sample value |
| a_tag | input | 4 | First path channel tag |
| b_valid | input | 1 | Second path offers a word this cycle |
| b_value | input | 12 | Second path sample value |
| b_tag | input | 4 | Second path channel tag |
| rd_strobe | input | 1 | Pop the oldest word into the read data register |
| irq_en | input | 1 | Enables the full interrupt |
| rd_data | output | 16 | Last popped word, tag in [15:12], value in [11:0] |
| level | output | 4 | Number of stored words, 0 to 8 |
| empty | output | 1 | No word stored |
| full | output | 1 | Eight words stored |
| overflow | output | 1 | Sticky flag: a word was dropped |
| irq | output | 1 | Full interrupt |

## Verification
The store path is tried with single words from each path in turn, with both paths at once into an empty buffer, and with both paths at once when only one slot is left. These cases separate the plain ordering, the same-cycle ordering by priority, and the rule that only the second word is dropped. Reads are tried on an empty buffer, on an empty buffer that also takes a push, and on a full buffer that takes a push in the same cycle. Together they show whether the pointers move only when they should and whether the level counts pushes and pops correctly at both ends. A full buffer is also checked with the interrupt enable set and cleared, and after a discarded write, to confirm that the overflow flag stays set.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   parameter int DEF_VAL_W = 12;
   parameter int DEF_TAG_W = 4;
   parameter int DEF_DEPTH = 8;

   // which producer wins the earlier slot when both offer a word together
   typedef enum logic {
      PRIO_A_FIRST = 1'b0,
      PRIO_B_FIRST = 1'b1
   } prio_e;
endpackage

// File: rtl/sfifo_arbiter.sv
module sfifo_arbiter #(
   parameter int W     = 16,
   parameter int DEPTH = 8,
   parameter int CNT_W = 4,
   parameter sfifo_pkg::prio_e PRIO = sfifo_pkg::PRIO_A_FIRST
) (
   input  logic             a_valid,
   input  logic [W-1:0]     a_word,
   input  logic             b_valid,
   input  logic [W-1:0]     b_word,
   input  logic [CNT_W-1:0] level,
   input  logic             pop,
   output logic             w0_vld,
   output logic [W-1:0]     w0_data,
   output logic             w1_vld,
   output logic [W-1:0]     w1_data,
   output logic             drop
);
   localparam logic [CNT_W:0] DEPTH_V = (CNT_W+1)'(DEPTH);

   logic           first_v, second_v;
   logic [W-1:0]   first_d, second_d;
   logic [CNT_W:0] free_slots;
   logic           take1, take2;

   generate
      if (PRIO == sfifo_pkg::PRIO_A_FIRST) begin : g_a_first
         assign first_v  = a_valid;
         assign first_d  = a_word;
         assign second_v = b_valid;
         assign second_d = b_word;
      end else begin : g_b_first
         assign first_v  = b_valid;
         assign first_d  = b_word;
         assign second_v = a_valid;
         assign second_d = a_word;
      end
   endgenerate

   always_comb begin
      free_slots = DEPTH_V - {1'b0, level} + {{CNT_W{1'b0}}, pop};
      take1      = first_v && (free_slots != '0);
      take2      = second_v &&
                   (free_slots >= (take1 ? (CNT_W+1)'(2) : (CNT_W+1)'(1)));
      w0_vld     = take1 | take2;
      w0_data    = take1 ? first_d : second_d;
      w1_vld     = take1 & take2;
      w1_data    = second_d;
      drop       = (first_v & ~take1) | (second_v & ~take2);
   end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int W     = 16,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         w0_vld,
   input  logic [W-1:0] w0_data,
   input  logic         w1_vld,
   input  logic [W-1:0] w1_data,
   input  logic         rd_strobe,
   input  logic         pop,
   output logic [W-1:0] rd_data
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx1;
   logic [1:0]       npush;

   assign wr_ptr_nx1 = wr_ptr + PTR_W'(1);
   assign npush      = {1'b0, w0_vld} + {1'b0, w1_vld};

   always_ff @(posedge clk) begin
      if (w0_vld) mem[wr_ptr]     <= w0_data;
      if (w1_vld) mem[wr_ptr_nx1] <= w1_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         rd_data <= '0;
      end else begin
         wr_ptr <= wr_ptr + PTR_W'(npush);
         if (pop) rd_ptr <= rd_ptr + PTR_W'(1);
         if (rd_strobe) rd_data <= pop ? mem[rd_ptr] : '0;
      end
   end
endmodule

// File: rtl/sfifo_status.sv
module sfifo_status #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             w0_vld,
   input  logic             w1_vld,
   input  logic             pop,
   input  logic             drop,
   input  logic             irq_en,
   output logic [CNT_W-1:0] level,
   output logic             empty,
   output logic             full,
   output logic             overflow,
   output logic             irq
);
   logic [1:0] npush;
   assign npush = {1'b0, w0_vld} + {1'b0, w1_vld};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level    <= '0;
         overflow <= 1'b0;
      end else begin
         level <= level + CNT_W'(npush) - CNT_W'(pop);
         if (drop) overflow <= 1'b1;
      end
   end

   assign empty = (level == '0);
   assign full  = (level == CNT_W'(DEPTH));
   assign irq   = full & irq_en;
endmodule

// File: rtl/tagged_sample_fifo.sv
module tagged_sample_fifo #(
   parameter int VAL_W = sfifo_pkg::DEF_VAL_W,
   parameter int TAG_W = sfifo_pkg::DEF_TAG_W,
   parameter int DEPTH = sfifo_pkg::DEF_DEPTH,
   parameter sfifo_pkg::prio_e PRIO = sfifo_pkg::PRIO_A_FIRST,
   localparam int W     = VAL_W + TAG_W,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_valid,
   input  logic [VAL_W-1:0] a_value,
   input  logic [TAG_W-1:0] a_tag,
   input  logic             b_valid,
   input  logic [VAL_W-1:0] b_value,
   input  logic [TAG_W-1:0] b_tag,
   input  logic             rd_strobe,
   input  logic             irq_en,
   output logic [W-1:0]     rd_data,
   output logic [CNT_W-1:0] level,
   output logic             empty,
   output logic             full,
   output logic             overflow,
   output logic             irq
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("tagged_sample_fifo: DEPTH must be a power of two, at least 2");
      end
      if (VAL_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("tagged_sample_fifo: field widths must be positive");
      end
   endgenerate

   logic         pop, drop;
   logic         w0_vld, w1_vld;
   logic [W-1:0] w0_data, w1_data;
   logic [W-1:0] a_word, b_word;

   assign a_word = {a_tag, a_value};
   assign b_word = {b_tag, b_value};
   assign pop    = rd_strobe & ~empty;

   sfifo_arbiter #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W), .PRIO(PRIO)) arb_i (
      .a_valid (a_valid),
      .a_word  (a_word),
      .b_valid (b_valid),
      .b_word  (b_word),
      .level   (level),
      .pop     (pop),
      .w0_vld  (w0_vld),
      .w0_data (w0_data),
      .w1_vld  (w1_vld),
      .w1_data (w1_data),
      .drop    (drop)
   );

   sfifo_store #(.W(W), .DEPTH(DEPTH)) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .w0_vld    (w0_vld),
      .w0_data   (w0_data),
      .w1_vld    (w1_vld),
      .w1_data   (w1_data),
      .rd_strobe (rd_strobe),
      .pop       (pop),
      .rd_data   (rd_data)
   );

   sfifo_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) status_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .w0_vld   (w0_vld),
      .w1_vld   (w1_vld),
      .pop      (pop),
      .drop     (drop),
      .irq_en   (irq_en),
      .level    (level),
      .empty    (empty),
      .full     (full),
      .overflow (overflow),
      .irq      (irq)
   );
endmodule

// File: rtl/tagged_sample_fifo_chk.sv
module tagged_sample_fifo_chk #(
   parameter int W     = 16,
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             a_valid,
   input logic             b_valid,
   input logic             rd_strobe,
   input logic             irq_en,
   input logic [W-1:0]     rd_data,
   input logic [CNT_W-1:0] level,
   input logic             empty,
   input logic             full,
   input logic             overflow,
   input logic             irq
);
   localparam int LIM = DEPTH;

   assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(level) <= LIM) && !(empty && full));

   assert_dual_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && b_valid && !rd_strobe && int'(level) <= LIM - 2)
      |=> int'(level) == int'($past(level)) + 2);

   assert_drop_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && b_valid && !rd_strobe && int'(level) == LIM - 1)
      |=> full && overflow);

   assert_sticky_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   assert_full_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_strobe && (a_valid || b_valid)) |=> full && overflow);

   assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && empty && !a_valid && !b_valid)
      |=> (rd_data == '0) && empty);

   assert_pushpop_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && rd_strobe && (a_valid || b_valid)) |=> full);

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (full && irq_en));

   assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> $stable(rd_data));
endmodule

bind tagged_sample_fifo tagged_sample_fifo_chk #(
   .W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .a_valid   (a_valid),
   .b_valid   (b_valid),
   .rd_strobe (rd_strobe),
   .irq_en    (irq_en),
   .rd_data   (rd_data),
   .level     (level),
   .empty     (empty),
   .full      (full),
   .overflow  (overflow),
   .irq       (irq)
);

// File: tb/tagged_sample_fifo_tb.sv
module tagged_sample_fifo_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_valid = 1'b0, b_valid = 1'b0;
   logic [11:0] a_value = '0, b_value = '0;
   logic [3:0]  a_tag = '0, b_tag = '0;
   logic        rd_strobe = 1'b0, irq_en = 1'b0;
   logic [15:0] rd_data;
   logic [3:0]  level;
   logic        empty, full, overflow, irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   tagged_sample_fifo dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_valid(a_valid), .a_value(a_value), .a_tag(a_tag),
      .b_valid(b_valid), .b_value(b_value), .b_tag(b_tag),
      .rd_strobe(rd_strobe), .irq_en(irq_en),
      .rd_data(rd_data), .level(level), .empty(empty), .full(full),
      .overflow(overflow), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, sample 1 ns after the rising edge
   task automatic step(input logic av, input logic [11:0] avl, input logic [3:0] at,
                       input logic bv, input logic [11:0] bvl, input logic [3:0] bt,
                       input logic rd);
      @(negedge clk);
      a_valid = av; a_value = avl; a_tag = at;
      b_valid = bv; b_value = bvl; b_tag = bt;
      rd_strobe = rd;
      @(posedge clk);
      #1;
      a_valid = 1'b0; b_valid = 1'b0; rd_strobe = 1'b0;
   endtask

   task automatic idle();
      step(1'b0, 12'h0, 4'h0, 1'b0, 12'h0, 4'h0, 1'b0);
   endtask

   task automatic rd1();
      step(1'b0, 12'h0, 4'h0, 1'b0, 12'h0, 4'h0, 1'b1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   // four dual pushes: A = {k, 0x200+k}, B = {k+8, 0x300+k}
   task automatic fill_dual();
      for (int k = 0; k < 4; k++)
         step(1'b1, 12'h200 + 12'(k), 4'(k), 1'b1, 12'h300 + 12'(k), 4'(k + 8), 1'b0);
   endtask

   task automatic t_reset();
      do_reset();
      check("R7 reset level", 32'(level), 0);
      check("R7 reset empty", 32'(empty), 1);
      check("R7 reset full", 32'(full), 0);
      check("R7 reset overflow", 32'(overflow), 0);
      check("R7 reset rd_data", 32'(rd_data), 0);
      check("R8 reset irq", 32'(irq), 0);
   endtask

   task automatic t_empty_read();
      do_reset();
      rd1();
      check("R5 empty read data", 32'(rd_data), 0);
      check("R5 empty read level", 32'(level), 0);
      step(1'b1, 12'h0AA, 4'h5, 1'b0, 12'h0, 4'h0, 1'b1);
      check("R5 empty read with push data", 32'(rd_data), 0);
      check("R5 empty read with push level", 32'(level), 1);
      rd1();
      check("R5 pushed word kept", 32'(rd_data), 32'h50AA);
      check("R7 empty after drain", 32'(empty), 1);
   endtask

   task automatic t_order_single();
      do_reset();
      step(1'b1, 12'h123, 4'h3, 1'b0, 12'h0, 4'h0, 1'b0);
      step(1'b0, 12'h0, 4'h0, 1'b1, 12'hABC, 4'h9, 1'b0);
      check("R7 level after two", 32'(level), 2);
      rd1();
      check("R1 first word packed", 32'(rd_data), 32'h3123);
      rd1();
      check("R1 second word packed", 32'(rd_data), 32'h9ABC);
      idle(); idle();
      check("R9 rd_data holds", 32'(rd_data), 32'h9ABC);
   endtask

   task automatic t_dual();
      do_reset();
      step(1'b1, 12'h001, 4'h1, 1'b1, 12'h002, 4'h2, 1'b0);
      check("R2 dual level", 32'(level), 2);
      check("R2 dual no overflow", 32'(overflow), 0);
      rd1();
      check("R2 first path first", 32'(rd_data), 32'h1001);
      rd1();
      check("R2 second path next", 32'(rd_data), 32'h2002);
   endtask

   task automatic t_last_slot();
      do_reset();
      for (int i = 0; i < 7; i++)
         step(1'b1, 12'h100 + 12'(i), 4'(i), 1'b0, 12'h0, 4'h0, 1'b0);
      check("R3 level seven", 32'(level), 7);
      step(1'b1, 12'h7AA, 4'h7, 1'b1, 12'h7BB, 4'h8, 1'b0);
      check("R3 full after contest", 32'(full), 1);
      check("R3 overflow set", 32'(overflow), 1);
      @(negedge clk); irq_en = 1'b1; #1;
      check("R8 irq enabled", 32'(irq), 1);
      @(negedge clk); irq_en = 1'b0; #1;
      check("R8 irq masked", 32'(irq), 0);
      for (int i = 0; i < 8; i++) rd1();
      check("R3 last word is first path", 32'(rd_data), 32'h77AA);
      check("R7 empty after drain", 32'(empty), 1);
   endtask

   task automatic t_full_write();
      do_reset();
      fill_dual();
      check("R7 full flag", 32'(full), 1);
      check("R4 no overflow yet", 32'(overflow), 0);
      step(1'b1, 12'hEEE, 4'hE, 1'b0, 12'h0, 4'h0, 1'b0);
      check("R4 level unchanged", 32'(level), 8);
      check("R4 overflow set", 32'(overflow), 1);
      idle(); idle(); idle();
      check("R4 overflow sticky", 32'(overflow), 1);
      rd1();
      check("R4 head unchanged", 32'(rd_data), 32'h0200);
      for (int i = 0; i < 7; i++) rd1();
      check("R4 tail unchanged", 32'(rd_data), 32'hB303);
      check("R4 sticky after drain", 32'(overflow), 1);
   endtask

   task automatic t_pushpop_full();
      do_reset();
      fill_dual();
      step(1'b1, 12'h5EE, 4'hF, 1'b0, 12'h0, 4'h0, 1'b1);
      check("R6 level stays full", 32'(level), 8);
      check("R6 read oldest", 32'(rd_data), 32'h0200);
      check("R6 no overflow", 32'(overflow), 0);
      for (int i = 0; i < 7; i++) rd1();
      check("R6 old tail", 32'(rd_data), 32'hB303);
      rd1();
      check("R6 new word last", 32'(rd_data), 32'hF5EE);
   endtask

   initial begin
      t_reset();
      t_empty_read();
      t_order_single();
      t_dual();
      t_last_slot();
      t_full_write();
      t_pushpop_full();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule